// File: doc/BRIEF.md
# Acknowledge-Polling Retry Sequencer

This block sits above a bit-level serial bus engine inside a bus master. It keeps addressing one target device until that device acknowledges. A write to the target-address register starts the sequence. The sequencer then asks the engine for an address-only attempt through a start/done/ack handshake. If the target does not acknowledge, it waits a programmable gap and tries again. When the target does acknowledge, the sequencer raises a one-cycle ready event and stops.

The gap is counted in serial-clock ticks. These are one-cycle enable pulses on the system clock, not a separate clock. The sequencer only runs while both master mode and the monitor enable are set. Clearing either one stops it at once.

The engine handshake has no back-pressure of its own. A start pulse hands the latched address to the engine. The engine must answer each start with exactly one done pulse, carrying the ack bit with it. Any done pulse that arrives when no attempt is outstanding is dropped. The block moves no data stream, so it has no valid/ready port.

Top module: `probe_retry_seq`

## Requirements
- R1: After reset `eng_start`, `busy` and `slave_ready` are 0 and the gap setting is 0.
- R2: An `addr_wr` pulse while `master_en` and `monitor_en` are both 1 makes `eng_start` high for exactly one cycle, in the cycle after the write. `busy` rises in that same cycle.
- R3: An `addr_wr` pulse while either enable is 0 starts nothing: `eng_start` and `busy` stay 0.
- R4: When `wide_addr` is 0 at the write, `eng_addr` carries `addr_wdata[6:0]` with bits 9..7 forced to 0, and `eng_wide` is 0. When `wide_addr` is 1, `eng_addr` carries all 10 bits and `eng_wide` is 1.
- R5: A done pulse with `eng_ack`=0 and gap setting 0 makes `eng_start` pulse in the very next cycle.
- R6: A done pulse with `eng_ack`=0 and gap setting P>0 makes `eng_start` pulse in the cycle after the P-th `tick` that follows the failure. Cycles without `tick` do not count toward the gap.
- R7: A done pulse with `eng_ack`=1 makes `slave_ready` high for exactly one cycle, in the next cycle, with `busy` already 0. After that, no `eng_start` appears until another address write.
- R8: Dropping `master_en` or `monitor_en` forces `eng_start` to 0 in the same cycle and `busy` to 0 after the next edge. Re-enabling does not resume the sequence.
- R9: A done pulse that arrives while no attempt is outstanding has no effect and produces no `slave_ready`.
- R10: An address write while a sequence is running restarts it with the new address. `eng_start` pulses in the next cycle.
- R11: `eng_addr` and `eng_wide` change only on an address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master mode selected |
| monitor_en | input | 1 | Acknowledge polling enabled |
| wide_addr | input | 1 | 1 = 10-bit target address, 0 = 7-bit |
| addr_wr | input | 1 | Address register write strobe; starts a sequence |
| addr_wdata | input | 10 | Address write data |
| gap_wr | input | 1 | Gap register write strobe |
| gap_wdata | input | 4 | Gap in serial-clock ticks (0 = retry at once) |
| tick | input | 1 | One-cycle serial-clock tick enable |
| eng_start | output | 1 | Request one address-only attempt |
| eng_addr | output | 10 | Target address for the engine |
| eng_wide | output | 1 | Address mode for the engine |
| eng_done | input | 1 | Attempt finished |
| eng_ack | input | 1 | Target acknowledged, valid with eng_done |
| slave_ready | output | 1 | One-cycle target-ready event |
| busy | output | 1 | Sequence in progress |

## Verification
The bench counts the exact cycle in which each retry starts after a failure, with gap 0 and with a gap padded by idle non-tick cycles. An off-by-one in the gap counter would move the start by a tick, and a design that counted clocks instead of ticks would start too early. It drops an enable in the middle of a gap and then re-enables. A design that failed to abort would launch again, and one that saved its state would resume. It also sends stray done pulses outside an attempt, writes a new address during an attempt, and uses narrow-mode addresses with high bits set. A faulty design would answer the stray done with a false ready event, keep the old address, or leak bits 9..7 onto the engine.

// File: rtl/probe_retry_pkg.sv
package probe_retry_pkg;
  localparam int ADDR_W   = 10;
  localparam int NARROW_W = 7;
  localparam int GAP_W    = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_GAP    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/probe_target_store.sv
module probe_target_store #(
  parameter int ADDR_W   = 10,
  parameter int NARROW_W = 7,
  parameter int GAP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              wide_addr,
  input  logic              gap_wr,
  input  logic [GAP_W-1:0]  gap_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wide_q,
  output logic [GAP_W-1:0]  gap_q
);
  localparam int HIGH_W = ADDR_W - NARROW_W;

  logic [ADDR_W-1:0] addr_masked;

  always_comb begin
    if (wide_addr) addr_masked = addr_wdata;
    else           addr_masked = {{HIGH_W{1'b0}}, addr_wdata[NARROW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wide_q <= 1'b0;
    end else if (addr_wr) begin
      addr_q <= addr_masked;
      wide_q <= wide_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_wr) gap_q <= gap_wdata;
  end
endmodule

// File: rtl/probe_gap_timer.sv
module probe_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [GAP_W-1:0] limit,
  output logic             expired
);
  logic [GAP_W-1:0] cnt;
  logic [GAP_W-1:0] last;

  assign last    = limit - 1'b1;
  assign expired = run && tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/probe_seq_fsm.sv
module probe_seq_fsm
  import probe_retry_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enabled,
  input  logic             addr_wr,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic [GAP_W-1:0] gap_q,
  input  logic             gap_expired,
  output logic             in_gap,
  output logic             eng_start,
  output logic             slave_ready,
  output logic             busy
);
  seq_state_t state, state_nx;
  logic       ready_q;
  logic       hit;

  assign hit = (state == ST_WAIT) && eng_done && eng_ack;

  always_comb begin
    state_nx = state;
    if (!enabled)     state_nx = ST_IDLE;
    else if (addr_wr) state_nx = ST_LAUNCH;
    else begin
      unique case (state)
        ST_IDLE:   state_nx = ST_IDLE;
        ST_LAUNCH: state_nx = ST_WAIT;
        ST_WAIT: begin
          if (eng_done) begin
            if (eng_ack)          state_nx = ST_IDLE;
            else if (gap_q == '0) state_nx = ST_LAUNCH;
            else                  state_nx = ST_GAP;
          end
        end
        ST_GAP:    if (gap_expired) state_nx = ST_LAUNCH;
        default:   state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state   <= state_nx;
      ready_q <= enabled && !addr_wr && hit;
    end
  end

  assign in_gap      = (state == ST_GAP);
  assign eng_start   = (state == ST_LAUNCH) && enabled;
  assign slave_ready = ready_q;
  assign busy        = (state != ST_IDLE);
endmodule

// File: rtl/probe_retry_seq.sv
module probe_retry_seq
  import probe_retry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              monitor_en,
  input  logic              wide_addr,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              gap_wr,
  input  logic [GAP_W-1:0]  gap_wdata,
  input  logic              tick,
  output logic              eng_start,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              eng_wide,
  input  logic              eng_done,
  input  logic              eng_ack,
  output logic              slave_ready,
  output logic              busy
);
  logic             enabled;
  logic [GAP_W-1:0] gap_q;
  logic             in_gap;
  logic             gap_expired;

  assign enabled = master_en && monitor_en;

  probe_target_store #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .GAP_W(GAP_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata), .wide_addr(wide_addr),
    .gap_wr(gap_wr), .gap_wdata(gap_wdata),
    .addr_q(eng_addr), .wide_q(eng_wide), .gap_q(gap_q)
  );

  probe_gap_timer #(.GAP_W(GAP_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(in_gap), .tick(tick), .limit(gap_q),
    .expired(gap_expired)
  );

  probe_seq_fsm #(.GAP_W(GAP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .enabled(enabled), .addr_wr(addr_wr),
    .eng_done(eng_done), .eng_ack(eng_ack),
    .gap_q(gap_q), .gap_expired(gap_expired),
    .in_gap(in_gap), .eng_start(eng_start),
    .slave_ready(slave_ready), .busy(busy)
  );
endmodule

// File: rtl/probe_retry_seq_chk.sv
module probe_retry_seq_chk
  import probe_retry_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              master_en,
  input logic              monitor_en,
  input logic              addr_wr,
  input logic              eng_start,
  input logic [ADDR_W-1:0] eng_addr,
  input logic              eng_wide,
  input logic              eng_done,
  input logic              eng_ack,
  input logic              slave_ready,
  input logic              busy
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && !addr_wr |=> !eng_start); // R2

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(master_en && monitor_en) |-> !eng_start); // R8

  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_wide |-> eng_addr[ADDR_W-1:NARROW_W] == '0); // R4

  AST_READY_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    slave_ready |-> $past(eng_done && eng_ack)); // R7

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slave_ready |=> !slave_ready); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    slave_ready |-> !busy); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(addr_wr) |-> $stable(eng_addr) && $stable(eng_wide)); // R11
endmodule

bind probe_retry_seq probe_retry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .monitor_en(monitor_en),
  .addr_wr(addr_wr), .eng_start(eng_start), .eng_addr(eng_addr),
  .eng_wide(eng_wide), .eng_done(eng_done), .eng_ack(eng_ack),
  .slave_ready(slave_ready), .busy(busy)
);

// File: tb/tb_probe_retry_seq.sv
module tb_probe_retry_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_en = 1'b0, monitor_en = 1'b0, wide_addr = 1'b0;
  logic       addr_wr = 1'b0, gap_wr = 1'b0, tick = 1'b0;
  logic [9:0] addr_wdata = '0;
  logic [3:0] gap_wdata = '0;
  logic       eng_done = 1'b0, eng_ack = 1'b0;
  logic       eng_start, eng_wide, slave_ready, busy;
  logic [9:0] eng_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  probe_retry_seq dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .monitor_en(monitor_en),
    .wide_addr(wide_addr), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .gap_wr(gap_wr), .gap_wdata(gap_wdata), .tick(tick),
    .eng_start(eng_start), .eng_addr(eng_addr), .eng_wide(eng_wide),
    .eng_done(eng_done), .eng_ack(eng_ack),
    .slave_ready(slave_ready), .busy(busy)
  );

  // {wide, write data, expected engine address}
  localparam logic [20:0] VECS [6] = '{
    {1'b0, 10'h3FF, 10'h07F},
    {1'b0, 10'h2A5, 10'h025},
    {1'b1, 10'h2A5, 10'h2A5},
    {1'b1, 10'h3FF, 10'h3FF},
    {1'b0, 10'h050, 10'h050},
    {1'b1, 10'h001, 10'h001}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_addr(input logic wide, input logic [9:0] a);
    wide_addr = wide; addr_wdata = a; addr_wr = 1'b1;
    step();
    addr_wr = 1'b0;
  endtask

  task automatic write_gap(input logic [3:0] g);
    gap_wdata = g; gap_wr = 1'b1;
    step();
    gap_wr = 1'b0;
  endtask

  task automatic answer(input logic ack);
    eng_done = 1'b1; eng_ack = ack;
    step();
    eng_done = 1'b0; eng_ack = 1'b0;
  endtask

  task automatic one_tick();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #5;
    check("R1 start", eng_start, 0);
    check("R1 busy", busy, 0);
    check("R1 ready", slave_ready, 0);
    rst_n = 1'b1;
    step();
    master_en = 1'b1; monitor_en = 1'b1;

    // R1: gap resets to 0, so a failure retries at once
    write_addr(1'b0, 10'h012);
    step();
    answer(1'b0);
    check("R1 gap zero retry", eng_start, 1);
    step();
    answer(1'b1);
    step();

    // Table walk: R2 start pulse, R4 address masking, R7 ready event
    for (int i = 0; i < 6; i++) begin
      write_addr(VECS[i][20], VECS[i][19:10]);
      check("R2 start", eng_start, 1);
      check("R2 busy", busy, 1);
      check("R4 addr", eng_addr, VECS[i][9:0]);
      check("R4 wide", eng_wide, VECS[i][20]);
      step();
      check("R2 single pulse", eng_start, 0);
      answer(1'b1);
      check("R7 ready", slave_ready, 1);
      check("R7 idle", busy, 0);
      step();
      check("R7 ready pulse", slave_ready, 0);
    end

    // R7: no further starts after success
    for (int i = 0; i < 4; i++) begin
      one_tick();
      check("R7 stays idle", eng_start | busy, 0);
    end

    // R3: write while disabled
    master_en = 1'b0;
    write_addr(1'b0, 10'h033);
    check("R3 no start master", eng_start, 0);
    check("R3 no busy master", busy, 0);
    master_en = 1'b1; monitor_en = 1'b0;
    write_addr(1'b0, 10'h034);
    check("R3 no start monitor", eng_start, 0);
    step();
    check("R3 no busy monitor", busy, 0);
    monitor_en = 1'b1;

    // R5: gap 0, repeated failures
    write_addr(1'b0, 10'h044);
    step();
    answer(1'b0);
    check("R5 immediate retry", eng_start, 1);
    step();
    answer(1'b0);
    check("R5 second retry", eng_start, 1);
    step();
    answer(1'b1);
    step();

    // R6: gap 3 ticks with idle cycles between
    write_gap(4'd3);
    write_addr(1'b1, 10'h155);
    step();
    answer(1'b0);
    check("R6 no start at failure", eng_start, 0);
    step(); step();
    check("R6 plain clocks ignored", eng_start, 0);
    one_tick(); step();
    check("R6 after tick 1", eng_start, 0);
    one_tick(); step(); step();
    check("R6 after tick 2", eng_start, 0);
    one_tick();
    check("R6 after tick 3", eng_start, 1);
    check("R6 addr kept", eng_addr, 10'h155);
    step();

    // R9: done while attempt outstanding is real; stray done in gap ignored
    answer(1'b0);
    answer(1'b1);
    check("R9 stray done in gap", slave_ready, 0);
    check("R9 still busy", busy, 1);

    // R8: abort during gap, re-enable does not resume
    monitor_en = 1'b0;
    #0;
    check("R8 start off", eng_start, 0);
    step();
    check("R8 busy off", busy, 0);
    monitor_en = 1'b1;
    for (int i = 0; i < 5; i++) one_tick();
    check("R8 no resume start", eng_start, 0);
    check("R8 no resume busy", busy, 0);

    // R9: stray done while idle
    answer(1'b1);
    check("R9 idle stray", slave_ready, 0);

    // R10: restart with new address during wait
    write_gap(4'd0);
    write_addr(1'b0, 10'h011);
    step();
    write_addr(1'b0, 10'h022);
    check("R10 restart start", eng_start, 1);
    check("R10 new addr", eng_addr, 10'h022);
    step();
    answer(1'b1);
    check("R10 ready", slave_ready, 1);

    // R11: address unchanged by a gap write
    write_gap(4'd2);
    check("R11 addr hold", eng_addr, 10'h022);

    step();
    finish_run();
  end
endmodule